// File: doc/BRIEF.md
# Dual-Port Wishbone Command Merger

This block sits between one core's two Wishbone master ports and a downstream command path. The core has a separate instruction-fetch port and a data port. Each port's request is latched into a one-entry slot as a 78-bit command word. The word also carries an 8-bit extension code that arrives on a shared input. A consumer downstream reads the slots and returns a 3-bit taken vector to free them. Each port has at most one command outstanding, so a new request on a port is refused while that port's slot is still occupied.

The downstream side is set by parameters. It can be a single command output or a pair of split outputs. On a single output fed by both ports, the block chooses a slot and keeps that choice until the chosen command is taken. It prefers the data slot when nothing is held yet. A flag tells the consumer which slot the single output carries, so that it can set the matching taken bit. With split outputs, or with only the data port configured, the slots are passed straight through.

Top module: `wbm_cmd_merge`

## Requirements
- R1: A command word has this layout: bit 77 valid, bit 76 write enable, bits 75:72 byte selects, bits 71:40 byte address, bits 39:8 write data, bits 7:0 extension code.
- R2: An instruction command has write enable, byte selects and write data all zero. Its address is the 30-bit word address followed by two zero bits, and it carries the extension code present at capture.
- R3: A data command carries write enable, byte selects, the 32-bit address, the write data and the extension code, exactly as they are sampled at capture.
- R4: A slot captures at the clock edge where its port's request (cyc AND stb) is high and was low at the previous edge. A request that is already high when reset ends counts as new. A request held high after its command was taken is not captured again.
- R5: While a slot holds a command that has not been taken, a new rising request on that port is dropped and the slot's contents are unchanged.
- R6: At the next edge, taken bit 0 empties the instruction slot and taken bit 1 empties the data slot. Both bits may be set together. Taken bit 2 has no effect. An empty slot presents an all-zero word.
- R7: In merge mode (two ports, one output), when no choice is held and the data slot is full, output 0 shows the data slot and the data flag is 1. Otherwise output 0 shows the instruction slot and the flag is 0. Output 1 is zero.
- R8: In merge mode, once a slot is shown on output 0, it stays shown for as long as it is full. This holds even if the other slot fills in the meantime. The choice is released in the cycle after that slot is taken.
- R9: In split mode, output 0 always equals the instruction slot, output 1 always equals the data slot, and the data flag is 0.
- R10: Reset is synchronous and active high. It empties both slots and drops any held choice, so every output reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_cyc | input | 1 | Instruction port bus cycle |
| i_stb | input | 1 | Instruction port strobe |
| i_adr | input | 30 | Instruction port word address |
| d_cyc | input | 1 | Data port bus cycle |
| d_stb | input | 1 | Data port strobe |
| d_we | input | 1 | Data port write enable |
| d_sel | input | 4 | Data port byte selects |
| d_adr | input | 32 | Data port byte address |
| d_wdat | input | 32 | Data port write data |
| ext_cmd | input | 8 | Extension code shared by both ports |
| taken | input | 3 | Bit 0 frees the instruction slot, bit 1 frees the data slot, bit 2 is reserved |
| out0 | output | 78 | Command output 0 |
| out1 | output | 78 | Command output 1 (split mode only, otherwise zero) |
| out0_is_data | output | 1 | Output 0 currently carries the data slot |

## Verification
Every internal state reaches the ports within one cycle, because both outputs are combinational views of the slots and of the held choice. A slot that fails to capture, a refused request that overwrites a slot, or a clear that is missed all show up on the next sampled output. A held choice that is lost only shows when the second slot fills while the first is still pending. The stimulus therefore arranges arrivals out of step across the two ports, and takes slots one at a time while their requests stay asserted.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SEL_W  = DATA_W / 8;
    localparam int EXT_W  = 8;
    localparam int WADR_W = ADDR_W - 2;
    localparam int TAKE_W = 3;
    localparam int SLOT_I = 0;
    localparam int SLOT_D = 1;

    typedef struct packed {
        logic              vld;
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic [EXT_W-1:0]  ext;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    function automatic cmd_t pack_instr(input logic [WADR_W-1:0] wadr,
                                        input logic [EXT_W-1:0]  ext);
        cmd_t c;
        c      = '0;
        c.vld  = 1'b1;
        c.addr = {wadr, 2'b00};
        c.ext  = ext;
        return c;
    endfunction

    function automatic cmd_t pack_data(input logic              we,
                                       input logic [SEL_W-1:0]  sel,
                                       input logic [ADDR_W-1:0] addr,
                                       input logic [DATA_W-1:0] wdat,
                                       input logic [EXT_W-1:0]  ext);
        cmd_t c;
        c.vld  = 1'b1;
        c.we   = we;
        c.sel  = sel;
        c.addr = addr;
        c.wdat = wdat;
        c.ext  = ext;
        return c;
    endfunction
endpackage

// File: rtl/wbm_slot.sv
module wbm_slot
    import wbm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  cmd_t word_in,
    input  logic take,
    output cmd_t word_q
);
    logic req_q;
    logic capture;

    assign capture = req && !req_q && !word_q.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            word_q <= '0;
        end else begin
            req_q <= req;
            if (capture) begin
                word_q <= word_in;
            end else if (take) begin
                word_q <= '0;
            end
        end
    end

    // R5
    full_slot_holds_chk: assert property (@(posedge clk) disable iff (rst)
        word_q.vld && !take |=> $stable(word_q));

    // R6
    take_empties_chk: assert property (@(posedge clk) disable iff (rst)
        word_q.vld && take |=> !word_q.vld);

    // R4
    fill_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(word_q.vld) |-> $past(req));
endmodule

// File: rtl/wbm_pick.sv
module wbm_pick (
    input  logic clk,
    input  logic rst,
    input  logic i_vld,
    input  logic d_vld,
    input  logic i_take,
    input  logic d_take,
    output logic pick_d
);
    logic hold_q;
    logic hold_d_q;
    logic chosen_vld;
    logic chosen_take;

    assign pick_d      = hold_q ? hold_d_q : d_vld;
    assign chosen_vld  = pick_d ? d_vld  : i_vld;
    assign chosen_take = pick_d ? d_take : i_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b0;
            hold_d_q <= 1'b0;
        end else begin
            hold_q   <= chosen_vld && !chosen_take;
            hold_d_q <= pick_d;
        end
    end

    // R8
    choice_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        chosen_vld && !chosen_take |=> $stable(pick_d));

    // R7
    lone_data_wins_chk: assert property (@(posedge clk) disable iff (rst)
        d_vld && !i_vld |-> pick_d);
endmodule

// File: rtl/wbm_cmd_merge.sv
module wbm_cmd_merge
    import wbm_pkg::*;
#(
    parameter bit DUAL_IN  = 1'b1,
    parameter bit DUAL_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_cyc,
    input  logic              i_stb,
    input  logic [WADR_W-1:0] i_adr,
    input  logic              d_cyc,
    input  logic              d_stb,
    input  logic              d_we,
    input  logic [SEL_W-1:0]  d_sel,
    input  logic [ADDR_W-1:0] d_adr,
    input  logic [DATA_W-1:0] d_wdat,
    input  logic [EXT_W-1:0]  ext_cmd,
    input  logic [TAKE_W-1:0] taken,
    output logic [CMD_W-1:0]  out0,
    output logic [CMD_W-1:0]  out1,
    output logic              out0_is_data
);
    cmd_t i_q;
    cmd_t d_q;
    cmd_t d_word;

    assign d_word = pack_data(d_we, d_sel, d_adr, d_wdat, ext_cmd);

    wbm_slot u_dslot (
        .clk    (clk),
        .rst    (rst),
        .req    (d_cyc && d_stb),
        .word_in(d_word),
        .take   (taken[SLOT_D]),
        .word_q (d_q)
    );

    generate
        if (DUAL_IN) begin : g_islot
            cmd_t i_word;
            assign i_word = pack_instr(i_adr, ext_cmd);
            wbm_slot u_islot (
                .clk    (clk),
                .rst    (rst),
                .req    (i_cyc && i_stb),
                .word_in(i_word),
                .take   (taken[SLOT_I]),
                .word_q (i_q)
            );
        end else begin : g_noislot
            assign i_q = '0;
        end

        if (DUAL_IN && DUAL_OUT) begin : g_split
            assign out0         = i_q;
            assign out1         = d_q;
            assign out0_is_data = 1'b0;
        end else if (DUAL_IN) begin : g_merge
            logic pick_d;
            wbm_pick u_pick (
                .clk   (clk),
                .rst   (rst),
                .i_vld (i_q.vld),
                .d_vld (d_q.vld),
                .i_take(taken[SLOT_I]),
                .d_take(taken[SLOT_D]),
                .pick_d(pick_d)
            );
            assign out0         = pick_d ? d_q : i_q;
            assign out1         = '0;
            assign out0_is_data = pick_d;

            // R7
            merge_shows_pending_chk: assert property (@(posedge clk) disable iff (rst)
                (i_q.vld || d_q.vld) |-> out0[CMD_W-1]);
        end else if (DUAL_OUT) begin : g_data_split
            assign out0         = '0;
            assign out1         = d_q;
            assign out0_is_data = 1'b0;
        end else begin : g_data_only
            assign out0         = d_q;
            assign out1         = '0;
            assign out0_is_data = 1'b1;
        end
    endgenerate

    // R6
    reserved_take_inert_chk: assert property (@(posedge clk) disable iff (rst)
        taken == 3'b100 && d_q.vld |=> d_q.vld);

    // R10
    reset_empties_chk: assert property (@(posedge clk)
        rst |=> !d_q.vld && !i_q.vld);
endmodule

// File: tb/tb_wbm_cmd_merge.sv
`timescale 1ns/1ps
module tb_wbm_cmd_merge;
    logic        clk = 1'b0;
    logic        rst;
    logic        i_cyc, i_stb;
    logic [29:0] i_adr;
    logic        d_cyc, d_stb, d_we;
    logic [3:0]  d_sel;
    logic [31:0] d_adr, d_wdat;
    logic [7:0]  ext_cmd;
    logic [2:0]  taken;
    logic [77:0] m_out0, m_out1, s_out0, s_out1;
    logic        m_isd, s_isd;

    int checks = 0;
    int errors = 0;

    logic [77:0] mi, md;
    logic        mpi, mpd, mh, mhd;

    always #10 clk = ~clk;

    wbm_cmd_merge dut (
        .clk(clk), .rst(rst), .i_cyc(i_cyc), .i_stb(i_stb), .i_adr(i_adr),
        .d_cyc(d_cyc), .d_stb(d_stb), .d_we(d_we), .d_sel(d_sel), .d_adr(d_adr),
        .d_wdat(d_wdat), .ext_cmd(ext_cmd), .taken(taken),
        .out0(m_out0), .out1(m_out1), .out0_is_data(m_isd));

    wbm_cmd_merge #(.DUAL_IN(1'b1), .DUAL_OUT(1'b1)) dut_split (
        .clk(clk), .rst(rst), .i_cyc(i_cyc), .i_stb(i_stb), .i_adr(i_adr),
        .d_cyc(d_cyc), .d_stb(d_stb), .d_we(d_we), .d_sel(d_sel), .d_adr(d_adr),
        .d_wdat(d_wdat), .ext_cmd(ext_cmd), .taken(taken),
        .out0(s_out0), .out1(s_out1), .out0_is_data(s_isd));

    function automatic logic [77:0] exp_iword(logic [29:0] a, logic [7:0] e);
        return {1'b1, 1'b0, 4'b0000, a, 2'b00, 32'h0, e};
    endfunction

    function automatic logic [77:0] exp_dword(logic w, logic [3:0] s, logic [31:0] a,
                                              logic [31:0] dat, logic [7:0] e);
        return {1'b1, w, s, a, dat, e};
    endfunction

    function automatic logic model_pick();
        return mh ? mhd : md[77];
    endfunction

    task automatic check(string tag, logic [77:0] got, logic [77:0] exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(string tag);
        logic pk, cv, ct, ri, rd;
        pk = model_pick();
        cv = pk ? md[77] : mi[77];
        ct = pk ? taken[1] : taken[0];
        ri = i_cyc & i_stb;
        rd = d_cyc & d_stb;
        @(posedge clk);
        mh  = cv & ~ct;
        mhd = pk;
        if (ri && !mpi && !mi[77]) mi = exp_iword(i_adr, ext_cmd);
        else if (taken[0])        mi = '0;
        if (rd && !mpd && !md[77]) md = exp_dword(d_we, d_sel, d_adr, d_wdat, ext_cmd);
        else if (taken[1])        md = '0;
        mpi = ri;
        mpd = rd;
        @(negedge clk);
        pk = model_pick();
        check(tag, m_out0, pk ? md : mi, "merge out0");
        check(tag, {77'h0, m_isd}, {77'h0, pk}, "merge data flag");
        check(tag, m_out1, 78'h0, "merge out1");
        check(tag, s_out0, mi, "split out0");
        check(tag, s_out1, md, "split out1");
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mi = '0; md = '0; mpi = 1'b0; mpd = 1'b0; mh = 1'b0; mhd = 1'b0;
        check(tag, m_out0, 78'h0, "reset out0");
        check(tag, s_out1, 78'h0, "reset split out1");
        check(tag, {77'h0, m_isd}, 78'h0, "reset flag");
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        i_cyc = 0; i_stb = 0; i_adr = '0; d_cyc = 0; d_stb = 0; d_we = 0;
        d_sel = '0; d_adr = '0; d_wdat = '0; ext_cmd = '0; taken = '0;
        @(negedge clk);
        do_reset("R10");

        // R2 / R1: instruction capture and field positions
        i_cyc = 1; i_stb = 1; i_adr = 30'h2ABCDEF1; ext_cmd = 8'h5A;
        step("R2");
        check("R1", {46'h0, m_out0[71:40]}, {46'h0, 30'h2ABCDEF1, 2'b00}, "address field");
        check("R2", {73'h0, m_out0[76:72]}, 78'h0, "we and sel fields");
        check("R2", {46'h0, m_out0[39:8]}, 78'h0, "write data field");
        check("R1", {70'h0, m_out0[7:0]}, {70'h0, 8'h5A}, "extension field");

        // R6 take instruction; R4 held request not recaptured
        taken = 3'b001;
        step("R6");
        taken = 3'b000;
        step("R4");
        check("R4", m_out0, 78'h0, "no recapture on held request");
        i_cyc = 0;
        step("R4");

        // R7 both arrive together: data wins
        i_cyc = 1; i_adr = 30'h0000_0123; ext_cmd = 8'h11;
        d_cyc = 1; d_stb = 1; d_we = 1; d_sel = 4'b1010;
        d_adr = 32'hCAFE_0004; d_wdat = 32'hDEAD_BEEF;
        step("R7");
        check("R7", {77'h0, m_isd}, {77'h0, 1'b1}, "data preferred");
        check("R3", m_out0, exp_dword(1'b1, 4'b1010, 32'hCAFE_0004, 32'hDEAD_BEEF, 8'h11), "data word");

        // take data: instruction shown next
        taken = 3'b010;
        step("R7");
        taken = 3'b000;
        d_cyc = 0;
        step("R8");
        // R8 data fills while instruction is held
        d_cyc = 1; d_adr = 32'h0000_0ABC; d_wdat = 32'h1234_5678; d_we = 0;
        step("R8");
        check("R8", {77'h0, m_isd}, 78'h0, "choice stays on instruction");

        // R5 new rising data request while slot full
        d_cyc = 0;
        step("R5");
        d_cyc = 1; d_adr = 32'hFFFF_0000; d_wdat = 32'h0;
        step("R5");
        check("R5", s_out1[71:40] == 32'h0000_0ABC ? 78'h1 : 78'h0, 78'h1, "full slot kept");

        // R6 reserved bit, then both freed together
        taken = 3'b100;
        step("R6");
        taken = 3'b011;
        step("R6");
        taken = 3'b000;
        step("R9");

        // randomized mix
        for (int n = 0; n < 600; n++) begin
            i_cyc = ($urandom % 4) != 0;
            i_stb = ($urandom % 3) != 0;
            d_cyc = ($urandom % 4) != 0;
            d_stb = ($urandom % 3) != 0;
            i_adr = 30'($urandom);
            d_we = 1'($urandom);
            d_sel = 4'($urandom);
            d_adr = $urandom;
            d_wdat = $urandom;
            ext_cmd = 8'($urandom);
            taken = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
            step((n % 2) == 0 ? "R3" : "R9");
        end

        taken = 3'b000;
        d_cyc = 1; d_stb = 1; i_cyc = 1; i_stb = 1;
        step("R8");
        do_reset("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule